// File: doc/BRIEF.md
# Stack Pointer and Context Save/Restore Sequencer

This unit keeps the stack pointer of a small 8-bit processor core. It turns that pointer into full 16-bit stack addresses and moves processor context between the core and stack RAM, one byte per clock. The pointer is 6 bits wide. Every address it produces falls in one fixed 64-byte page at the top of the first 256 bytes. If too many bytes are pushed, the pointer simply wraps inside that page.

The core gives five one-cycle command strobes: stack reset, subroutine call, subroutine return, interrupt entry and interrupt return. It also presents the register values to save. The unit then drives a single-port memory interface with a write enable, a read enable, an address, write data and combinational read data. While a sequence runs, `busy` is high. A one-cycle `done` pulse marks the end of the sequence. Restored values appear on dedicated outputs and stay there until a later pull sequence overwrites them.

Top module: `stack_ctx_unit`

## Requirements
- R1: Reset, and the stack-reset strobe accepted while idle, both set the pointer so that the idle `mem_addr` reads 16'h00FF. The stack-reset strobe causes no busy period and no memory access.
- R2: Every address on `mem_addr` has bits [15:6] equal to 10'b0000000011 and the pointer in bits [5:0], so it lies in 16'h00C0..16'h00FF.
- R3: Each stack byte takes exactly one cycle. A push writes at the current pointer and then decrements the pointer. A pull first increments the pointer and then reads at the new value. While idle, `mem_addr` shows the next free location.
- R4: Pushing more than 64 bytes wraps the pointer modulo 64 with no error indication, and the oldest bytes are overwritten.
- R5: A call writes two bytes: PC[7:0] at the current pointer, then PC[15:8] one below it. The PC is captured in the cycle the strobe is accepted.
- R6: A return reads two bytes, PC[15:8] first and then PC[7:0], and places them on `pc_out`.
- R7: Interrupt entry writes five bytes in this order: PC[7:0], PC[15:8], X, A, then {3'b000, CCR}.
- R8: Interrupt return reads five bytes in the reverse order (CCR, A, X, PC[15:8], PC[7:0]). From the CCR byte only bits [4:0] are kept, and bits [7:5] are ignored.
- R9: `busy` is high for exactly as many cycles as the frame has bytes, starting in the cycle after the strobe. `done` is high for exactly the one cycle after the last byte, and `busy` is low in that cycle.
- R10: All strobes, including stack reset, are ignored while `busy` is high.
- R11: `pc_out`, `x_out`, `a_out` and `ccr_out` change only during pull cycles. A return leaves `x_out`, `a_out` and `ccr_out` unchanged.
- R12: When several strobes arrive together while idle, the priority is stack reset, then interrupt entry, then interrupt return, then call, then return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_rsp | input | 1 | Stack-reset strobe |
| cmd_call | input | 1 | Subroutine call strobe |
| cmd_ret | input | 1 | Subroutine return strobe |
| cmd_irq | input | 1 | Interrupt entry strobe |
| cmd_rti | input | 1 | Interrupt return strobe |
| pc_in | input | 16 | Program counter to save |
| x_in | input | 8 | Index register to save |
| a_in | input | 8 | Accumulator to save |
| ccr_in | input | 5 | Condition codes to save |
| mem_addr | output | 16 | Stack address |
| mem_we | output | 1 | Byte write enable |
| mem_re | output | 1 | Byte read enable |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read (combinational) |
| pc_out | output | 16 | Restored program counter |
| x_out | output | 8 | Restored index register |
| a_out | output | 8 | Restored accumulator |
| ccr_out | output | 5 | Restored condition codes |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The bench pushes 66 bytes so that the pointer wraps. A design that clamped or flagged the overflow, or that leaked a carry into bit 6 of the address, would put the wrong address on the bus or return the wrong frame. It also fires strobes in the middle of a sequence, including a stack reset. A design that restarted, or that moved the pointer on such a strobe, would emit extra or shifted bytes. Simultaneous strobes check the priority, and a poisoned CCR byte with its upper bits set catches a restore that keeps bits [7:5]. The bench also confirms that a return leaves X, A and CCR alone, which catches a design that reloads every output on each pull.

// File: rtl/stack_ctx_unit.sv
module stack_ctx_unit #(
  parameter int PTR_W  = 6,
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8,
  parameter int CC_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_rsp,
  input  logic              cmd_call,
  input  logic              cmd_ret,
  input  logic              cmd_irq,
  input  logic              cmd_rti,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [BYTE_W-1:0] x_in,
  input  logic [BYTE_W-1:0] a_in,
  input  logic [CC_W-1:0]   ccr_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic              mem_re,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] pc_out,
  output logic [BYTE_W-1:0] x_out,
  output logic [BYTE_W-1:0] a_out,
  output logic [CC_W-1:0]   ccr_out,
  output logic              busy,
  output logic              done
);

  localparam int HI_W = ADDR_W - PTR_W;
  localparam logic [HI_W-1:0] PAGE = HI_W'(3);
  localparam logic [PTR_W-1:0] TOP = '1;

  typedef enum logic [2:0] {OP_IDLE, OP_CALL, OP_RET, OP_IRQ, OP_RTI} op_t;

  op_t              op;
  logic [2:0]       step;
  logic [PTR_W-1:0] sp;
  logic [ADDR_W-1:0] pc_s;
  logic [BYTE_W-1:0] x_s, a_s;
  logic [CC_W-1:0]   ccr_s;
  logic [2:0]       slot;

  wire idle    = (op == OP_IDLE);
  wire pushing = (op == OP_CALL) || (op == OP_IRQ);
  wire pulling = (op == OP_RET)  || (op == OP_RTI);
  wire big     = (op == OP_IRQ)  || (op == OP_RTI);
  wire [2:0] last = big ? 3'd4 : 3'd1;
  wire [PTR_W-1:0] sp_up = sp + 1'b1;

  assign busy     = !idle;
  assign mem_we   = pushing;
  assign mem_re   = pulling;
  assign mem_addr = {PAGE, pulling ? sp_up : sp};
  assign slot     = pulling ? (last - step) : step;

  always_comb begin
    case (slot)
      3'd0:    mem_wdata = pc_s[7:0];
      3'd1:    mem_wdata = pc_s[15:8];
      3'd2:    mem_wdata = x_s;
      3'd3:    mem_wdata = a_s;
      default: mem_wdata = BYTE_W'(ccr_s);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op      <= OP_IDLE;
      step    <= '0;
      sp      <= TOP;
      done    <= 1'b0;
      pc_s    <= '0;
      x_s     <= '0;
      a_s     <= '0;
      ccr_s   <= '0;
      pc_out  <= '0;
      x_out   <= '0;
      a_out   <= '0;
      ccr_out <= '0;
    end else begin
      done <= 1'b0;
      if (idle) begin
        step <= '0;
        if (cmd_rsp) begin
          sp <= TOP;
        end else if (cmd_irq) begin
          op    <= OP_IRQ;
          pc_s  <= pc_in;
          x_s   <= x_in;
          a_s   <= a_in;
          ccr_s <= ccr_in;
        end else if (cmd_rti) begin
          op <= OP_RTI;
        end else if (cmd_call) begin
          op   <= OP_CALL;
          pc_s <= pc_in;
        end else if (cmd_ret) begin
          op <= OP_RET;
        end
      end else begin
        sp <= pushing ? sp - 1'b1 : sp_up;
        if (pulling) begin
          case (slot)
            3'd0:    pc_out[7:0]  <= mem_rdata;
            3'd1:    pc_out[15:8] <= mem_rdata;
            3'd2:    x_out        <= mem_rdata;
            3'd3:    a_out        <= mem_rdata;
            default: ccr_out      <= mem_rdata[CC_W-1:0];
          endcase
        end
        if (step == last) begin
          op   <= OP_IDLE;
          done <= 1'b1;
        end else begin
          step <= step + 1'b1;
        end
      end
    end
  end

  p_push_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && step != last) |=> (mem_we && mem_addr[PTR_W-1:0] == $past(mem_addr[PTR_W-1:0]) - 1'b1));

  p_pull_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re && step != last) |=> (mem_re && mem_addr[PTR_W-1:0] == $past(mem_addr[PTR_W-1:0]) + 1'b1));

  p_one_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  p_rsp_top_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_rsp) |=> (!busy && mem_addr == {PAGE, TOP}));

  p_done_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_keep_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && step != last) |=> busy);

  p_hold_out_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_re |=> $stable({pc_out, x_out, a_out, ccr_out}));

endmodule

// File: tb/test_stack_ctx_unit.sv
module test_stack_ctx_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_rsp = 0, cmd_call = 0, cmd_ret = 0, cmd_irq = 0, cmd_rti = 0;
  logic [15:0] pc_in = '0;
  logic [7:0]  x_in = '0, a_in = '0;
  logic [4:0]  ccr_in = '0;
  logic [15:0] mem_addr;
  logic        mem_we, mem_re;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [15:0] pc_out;
  logic [7:0]  x_out, a_out;
  logic [4:0]  ccr_out;
  logic        busy, done;

  always #2.5 clk = ~clk;

  stack_ctx_unit i_stack_ctx_unit (
    .clk, .rst_n, .cmd_rsp, .cmd_call, .cmd_ret, .cmd_irq, .cmd_rti,
    .pc_in, .x_in, .a_in, .ccr_in, .mem_addr, .mem_we, .mem_re,
    .mem_wdata, .mem_rdata, .pc_out, .x_out, .a_out, .ccr_out, .busy, .done);

  logic [7:0] ram [256];
  logic       poke_en = 0;
  logic [7:0] poke_a = '0, poke_d = '0;
  assign mem_rdata = ram[mem_addr[7:0]];
  always @(posedge clk) begin
    if (mem_we) ram[mem_addr[7:0]] <= mem_wdata;
    else if (poke_en) ram[poke_a] <= poke_d;
  end

  typedef struct { logic we; logic [15:0] addr; logic [7:0] data; } item_t;
  item_t q[$];
  int n_chk = 0, n_fail = 0;
  logic [5:0] msp;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic exp_push(input logic [7:0] d);
    q.push_back('{1'b1, {10'b0000000011, msp}, d});
    msp = msp - 1'b1;
  endtask

  task automatic exp_pull();
    msp = msp + 1'b1;
    q.push_back('{1'b0, {10'b0000000011, msp}, 8'h00});
  endtask

  // monitor: R2/R3/R5/R6/R7/R8 byte order and address
  always @(negedge clk) begin
    if (rst_n && (mem_we || mem_re)) begin
      if (q.size() == 0) begin
        chk(0, "R10 unexpected access", {15'd0, mem_we, mem_addr}, 32'h0);
      end else begin
        item_t e;
        e = q.pop_front();
        chk(mem_we == e.we && mem_addr == e.addr && (!e.we || mem_wdata == e.data),
            "R3 byte access",
            {7'd0, mem_we, mem_addr, mem_wdata}, {7'd0, e.we, e.addr, e.data});
        chk(mem_addr[15:6] == 10'b0000000011, "R2 page", {16'd0, mem_addr}, 32'h00C0);
      end
    end
  end

  task automatic strobe(input bit rsp, input bit irq, input bit rti, input bit call, input bit ret);
    @(negedge clk);
    cmd_rsp = rsp; cmd_irq = irq; cmd_rti = rti; cmd_call = call; cmd_ret = ret;
    @(negedge clk);
    cmd_rsp = 0; cmd_irq = 0; cmd_rti = 0; cmd_call = 0; cmd_ret = 0;
  endtask

  task automatic finish_seq(input int nbytes, input string tag);
    int n = 0;
    while (busy && n < 20) begin n++; @(negedge clk); end
    chk(n == nbytes, tag, n, nbytes);
    chk(done == 1'b1, "R9 done after last byte", done, 1);
    @(negedge clk);
    chk(done == 1'b0, "R9 done one cycle", done, 0);
  endtask

  task automatic do_call(input logic [15:0] pc);
    pc_in = pc;
    exp_push(pc[7:0]); exp_push(pc[15:8]);
    strobe(0, 0, 0, 1, 0);
    pc_in = 16'hDEAD;
    finish_seq(2, "R5 call busy cycles");
  endtask

  task automatic do_ret(input logic [15:0] pc_exp);
    exp_pull(); exp_pull();
    strobe(0, 0, 0, 0, 1);
    finish_seq(2, "R6 ret busy cycles");
    chk(pc_out == pc_exp, "R6 restored pc", pc_out, pc_exp);
  endtask

  task automatic push_irq_exp(input logic [15:0] pc, input logic [7:0] x, input logic [7:0] a, input logic [4:0] c);
    exp_push(pc[7:0]); exp_push(pc[15:8]); exp_push(x); exp_push(a); exp_push({3'b000, c});
  endtask

  initial begin
    msp = 6'h3F;
    for (int i = 0; i < 256; i++) ram[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(mem_addr == 16'h00FF, "R1 reset pointer", mem_addr, 16'h00FF);
    chk(!busy && !done, "R9 idle after reset", {busy, done}, 0);
    rst_n = 1;
    @(negedge clk);

    // R5 / R6 call frame
    do_call(16'h1234);
    chk(mem_addr == 16'h00FD, "R3 idle next free", mem_addr, 16'h00FD);

    // R7 interrupt frame; R10 strobes mid-sequence ignored
    pc_in = 16'hABCD; x_in = 8'h11; a_in = 8'h22; ccr_in = 5'h1F;
    push_irq_exp(16'hABCD, 8'h11, 8'h22, 5'h1F);
    strobe(0, 1, 0, 0, 0);
    pc_in = '0; x_in = '0; a_in = '0; ccr_in = '0;
    cmd_call = 1; cmd_rsp = 1;
    @(negedge clk);
    cmd_call = 0; cmd_rsp = 0;
    finish_seq(4, "R10 irq busy remaining cycles");
    chk(mem_addr == 16'h00F8, "R10 pointer untouched", mem_addr, 16'h00F8);

    // R8 poison ccr byte upper bits
    poke_en = 1; poke_a = 8'hF9; poke_d = 8'hE5;
    @(negedge clk);
    poke_en = 0;
    repeat (5) exp_pull();
    strobe(0, 0, 1, 0, 0);
    finish_seq(5, "R8 rti busy cycles");
    chk(ccr_out == 5'h05, "R8 ccr upper bits ignored", ccr_out, 5'h05);
    chk(a_out == 8'h22 && x_out == 8'h11, "R8 a/x restored", {a_out, x_out}, 16'h2211);
    chk(pc_out == 16'hABCD, "R8 pc restored", pc_out, 16'hABCD);

    // R6 return; R11 x/a/ccr unaffected
    do_ret(16'h1234);
    chk({x_out, a_out, ccr_out} == {8'h11, 8'h22, 5'h05}, "R11 ret keeps x/a/ccr",
        {x_out, a_out, 3'b0, ccr_out}, {8'h11, 8'h22, 8'h05});
    do_call(16'h5678);
    chk(pc_out == 16'h1234, "R11 push keeps outputs", pc_out, 16'h1234);
    do_ret(16'h5678);

    // R12 priority
    pc_in = 16'h0F0F;
    strobe(1, 1, 1, 1, 1);
    chk(!busy && mem_addr == 16'h00FF, "R12 stack reset wins", {busy, mem_addr}, 17'h000FF);
    msp = 6'h3F;
    x_in = 8'h33; a_in = 8'h44; ccr_in = 5'h0A;
    push_irq_exp(16'h0F0F, 8'h33, 8'h44, 5'h0A);
    strobe(0, 1, 1, 1, 1);
    finish_seq(5, "R12 irq beats call");
    repeat (5) exp_pull();
    strobe(0, 0, 1, 1, 1);
    finish_seq(5, "R12 rti beats call/ret");
    chk(a_out == 8'h44 && ccr_out == 5'h0A, "R12 rti data", {a_out, 3'b0, ccr_out}, 16'h440A);

    // R4 wrap
    strobe(1, 0, 0, 0, 0);
    msp = 6'h3F;
    chk(!busy && mem_addr == 16'h00FF, "R1 stack reset cmd", mem_addr, 16'h00FF);
    for (int i = 0; i < 33; i++) do_call(16'h1000 + 16'(i));
    chk(mem_addr == 16'h00FD, "R4 wrapped pointer", mem_addr, 16'h00FD);
    do_ret(16'h1020);
    do_ret(16'h101F);

    repeat (2) @(negedge clk);
    chk(q.size() == 0, "R3 all expected bytes seen", q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL R9 watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule